// File: doc/BRIEF.md
# Nested stack frame entry sequencer

This block performs the entry step of a block-structured procedure on a 16-bit word stack. The caller gives it the current stack pointer, the current frame pointer, a local-storage size in bytes and a lexical nesting level. The sequencer first pushes the old frame pointer. It then copies the chain of enclosing frame pointers onto the stack, one word for each enclosing level. If the level is nonzero it also pushes the new frame base. Last, it returns the new frame pointer and a stack pointer lowered by the local-storage size.

All stack traffic goes through a single-port word memory request interface that allows one access at a time. The block drives `mem_req` and waits for `mem_ack`. The caller pulses `start` while the block is idle and collects the two results on the cycle that `done` is high. Instruction decoding, segment translation, stack-limit checks and the matching exit step belong to other blocks.

Top module: `frame_entry_seq`

## Requirements
- R1: The first memory access after an accepted start is a write (`mem_we`=1) of `fp_in` to address `sp_in`-2. Every push lowers the working stack pointer by 2 and then writes at the lowered address.
- R2: With a nesting level of 0, the only memory access is the push of `fp_in`. No read takes place and no temporary frame value is pushed.
- R3: With a nesting level L>0, the first push is followed by L-1 read/push pairs. Pair k (k=1..L-1) reads the word at `fp_in`-2k (`mem_we`=0) and then pushes that same word at the next stack slot.
- R4: With a nesting level L>0, the last access is a push of the temporary frame value. This value is `sp_in`-2, the stack pointer right after the first push.
- R5: When the sequence finishes, `fp_out` equals `sp_in`-2. `sp_out` equals the working stack pointer after all pushes minus `size_in`, which is `sp_in`-2-(L>0 ? 2L : 0)-`size_in`.
- R6: Only `level_in[4:0]` sets the nesting level. Bits 7:5 have no effect on the accesses or the results.
- R7: At most one access is outstanding. While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` keep their values. No request is made while the block is idle.
- R8: A `start` pulse that arrives while `busy` is high is ignored. The running sequence and its results are unchanged.
- R9: After reset, `busy`, `done` and `mem_req` are 0. `busy` is high from the cycle after an accepted start until the sequence ends. `done` is a one-cycle pulse, and `sp_out`/`fp_out` are valid in that same cycle.
- R10: All pointer and address arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame entry (taken only when idle) |
| sp_in | input | 16 | Stack pointer before entry |
| fp_in | input | 16 | Frame pointer before entry |
| size_in | input | 16 | Local storage to allocate, in bytes |
| level_in | input | 8 | Lexical nesting level; low 5 bits used |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 16 | Stack pointer after entry |
| fp_out | output | 16 | Frame pointer after entry |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write (push), 0 = read |
| mem_addr | output | 16 | Byte address of the word accessed |
| mem_wdata | output | 16 | Word to write |
| mem_ack | input | 1 | Access completed this cycle |
| mem_rdata | input | 16 | Word read, valid with `mem_ack` |

## Verification
The sequence is run at levels 0, 1, 2 and 31, so that the no-copy path, the path that pushes only the frame value, a single copy and the longest chain are each observed. A level byte with its upper bits set and the same low bits as a plain case shows that those bits are ignored. A stack and frame pointer placed just above zero show the wrap of the addresses. Random pointers, sizes, levels and acknowledge delays are then compared access by access against a bench model. A start pulse injected in the middle of a run shows that the run's trace and results do not change.

// File: rtl/fes_pkg.sv
package fes_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned STEP   = 2;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PUSH_FP,
    S_READ,
    S_PUSH_CP,
    S_PUSH_TMP,
    S_FINISH
  } fes_state_t;

  // one stack slot downward, wraps modulo 2^WORD_W
  function automatic word_t step_down(input word_t v);
    return v - word_t'(STEP);
  endfunction

  // carve local storage below the pushed words
  function automatic word_t alloc_sp(input word_t sp, input word_t size);
    return sp - size;
  endfunction
endpackage

// File: rtl/fes_copy_ctr.sv
module fes_copy_ctr #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          last,
  output logic          empty
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - CW'(1);
  end

  assign last  = (cnt == CW'(1));
  assign empty = (cnt == '0);
endmodule

// File: rtl/fes_req_gen.sv
module fes_req_gen
  import fes_pkg::*;
(
  input  fes_state_t state,
  input  word_t      sp_work,
  input  word_t      bp_work,
  input  word_t      hold_word,
  input  word_t      tmp_frame,
  output logic       req,
  output logic       we,
  output word_t      addr,
  output word_t      wdata
);
  always_comb begin
    req   = 1'b0;
    we    = 1'b0;
    addr  = '0;
    wdata = '0;
    case (state)
      S_PUSH_FP: begin
        req = 1'b1; we = 1'b1;
        addr = step_down(sp_work); wdata = bp_work;
      end
      S_READ: begin
        req = 1'b1;
        addr = step_down(bp_work);
      end
      S_PUSH_CP: begin
        req = 1'b1; we = 1'b1;
        addr = step_down(sp_work); wdata = hold_word;
      end
      S_PUSH_TMP: begin
        req = 1'b1; we = 1'b1;
        addr = step_down(sp_work); wdata = tmp_frame;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/frame_entry_seq.sv
module frame_entry_seq
  import fes_pkg::*;
#(
  parameter int unsigned LVL_IN_W = 8,
  parameter int unsigned LVL_BITS = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [WORD_W-1:0]   sp_in,
  input  logic [WORD_W-1:0]   fp_in,
  input  logic [WORD_W-1:0]   size_in,
  input  logic [LVL_IN_W-1:0] level_in,
  output logic                busy,
  output logic                done,
  output logic [WORD_W-1:0]   sp_out,
  output logic [WORD_W-1:0]   fp_out,
  output logic                mem_req,
  output logic                mem_we,
  output logic [WORD_W-1:0]   mem_addr,
  output logic [WORD_W-1:0]   mem_wdata,
  input  logic                mem_ack,
  input  logic [WORD_W-1:0]   mem_rdata
);
  fes_state_t state;
  word_t      sp_work, bp_work, tmp_frame, hold_word, size_r;
  logic       lvl_nz;

  logic [LVL_BITS-1:0] lvl;
  logic                unused_lvl_hi;
  assign lvl           = level_in[LVL_BITS-1:0];
  assign unused_lvl_hi = ^level_in[LVL_IN_W-1:LVL_BITS];

  // named events for the checker
  logic accept, push_fire, read_fire, ctr_last, ctr_empty;
  assign accept    = (state == S_IDLE) && start;
  assign push_fire = mem_req && mem_we && mem_ack;
  assign read_fire = mem_req && !mem_we && mem_ack;

  fes_copy_ctr #(.CW(LVL_BITS)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val ((lvl == '0) ? '0 : lvl - LVL_BITS'(1)),
    .dec      ((state == S_PUSH_CP) && mem_ack),
    .last     (ctr_last),
    .empty    (ctr_empty)
  );

  fes_req_gen u_req (
    .state     (state),
    .sp_work   (sp_work),
    .bp_work   (bp_work),
    .hold_word (hold_word),
    .tmp_frame (tmp_frame),
    .req       (mem_req),
    .we        (mem_we),
    .addr      (mem_addr),
    .wdata     (mem_wdata)
  );

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      sp_work   <= '0;
      bp_work   <= '0;
      tmp_frame <= '0;
      hold_word <= '0;
      size_r    <= '0;
      lvl_nz    <= 1'b0;
      sp_out    <= '0;
      fp_out    <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          sp_work <= sp_in;
          bp_work <= fp_in;
          size_r  <= size_in;
          lvl_nz  <= (lvl != '0);
          state   <= S_PUSH_FP;
        end
        S_PUSH_FP: if (mem_ack) begin
          sp_work   <= step_down(sp_work);
          tmp_frame <= step_down(sp_work);
          if (!lvl_nz)        state <= S_FINISH;
          else if (ctr_empty) state <= S_PUSH_TMP;
          else                state <= S_READ;
        end
        S_READ: if (mem_ack) begin
          bp_work   <= step_down(bp_work);
          hold_word <= mem_rdata;
          state     <= S_PUSH_CP;
        end
        S_PUSH_CP: if (mem_ack) begin
          sp_work <= step_down(sp_work);
          state   <= ctr_last ? S_PUSH_TMP : S_READ;
        end
        S_PUSH_TMP: if (mem_ack) begin
          sp_work <= step_down(sp_work);
          state   <= S_FINISH;
        end
        S_FINISH: begin
          sp_out <= alloc_sp(sp_work, size_r);
          fp_out <= tmp_frame;
          done   <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fes_checker.sv
module fes_checker
  import fes_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  start,
  input logic  busy,
  input logic  done,
  input logic  mem_req,
  input logic  mem_we,
  input word_t mem_addr,
  input word_t mem_wdata,
  input logic  mem_ack,
  input logic  push_fire,
  input logic  read_fire,
  input word_t sp_work,
  input word_t bp_work
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy); // R9
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> sp_work == word_t'($past(sp_work) - word_t'(STEP))); // R10
  AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    read_fire |=> bp_work == word_t'($past(bp_work) - word_t'(STEP))); // R3
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !push_fire && !read_fire |=> $stable(sp_work) && $stable(bp_work)); // R8
endmodule

bind frame_entry_seq fes_checker u_fes_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .push_fire (push_fire),
  .read_fire (read_fire),
  .sp_work   (sp_work),
  .bp_work   (bp_work)
);

// File: tb/frame_entry_seq_bench.sv
`timescale 1ns/1ps
module frame_entry_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] sp_in, fp_in, size_in;
  logic [7:0]  level_in;
  logic        busy, done;
  logic [15:0] sp_out, fp_out;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic        mem_ack;
  logic [15:0] mem_rdata;

  always #4 clk = ~clk;

  frame_entry_seq u_frame_entry_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .sp_in(sp_in), .fp_in(fp_in), .size_in(size_in), .level_in(level_in),
    .busy(busy), .done(done), .sp_out(sp_out), .fp_out(fp_out),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // observed and expected access traces
  logic        tr_we[64];
  logic [15:0] tr_addr[64], tr_data[64];
  int          tr_n;
  logic        ex_we[64];
  logic [15:0] ex_addr[64], ex_data[64];
  int          ex_n;
  logic [15:0] ex_sp, ex_fp;

  function automatic logic [15:0] mem_word(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic add_ex(input logic we, input logic [15:0] a, input logic [15:0] d);
    ex_we[ex_n] = we; ex_addr[ex_n] = a; ex_data[ex_n] = d; ex_n++;
  endtask

  // bench model of the entry step
  task automatic model(input logic [15:0] sp, input logic [15:0] fp,
                       input logic [15:0] sz, input logic [7:0] lv8);
    int lv = int'(lv8 & 8'h1F);
    logic [15:0] s = sp, b = fp, t;
    ex_n = 0;
    s = s - 16'd2; add_ex(1'b1, s, fp);
    t = s;
    if (lv > 0) begin
      for (int k = 1; k < lv; k++) begin
        b = b - 16'd2;
        add_ex(1'b0, b, 16'h0);
        s = s - 16'd2;
        add_ex(1'b1, s, mem_word(b));
      end
      s = s - 16'd2; add_ex(1'b1, s, t);
    end
    ex_fp = t;
    ex_sp = s - sz;
  endtask

  // memory responder: random latency 0..2, grants at the falling edge
  initial begin
    int unsigned wl = 0;
    mem_ack = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        wl = $urandom_range(0, 2);
      end else if (rst_n && mem_req) begin
        if (wl == 0) begin
          mem_ack   = 1'b1;
          mem_rdata = mem_we ? 16'h0 : mem_word(mem_addr);
          if (tr_n < 64) begin
            tr_we[tr_n]   = mem_we;
            tr_addr[tr_n] = mem_addr;
            tr_data[tr_n] = mem_we ? mem_wdata : 16'h0;
          end
          tr_n++;
        end else wl--;
      end
    end
  end

  task automatic run_case(input logic [15:0] sp, input logic [15:0] fp,
                          input logic [15:0] sz, input logic [7:0] lv8,
                          input bit poke, input string tag);
    int cyc = 0;
    int lv = int'(lv8 & 8'h1F);
    int bad = 0;
    model(sp, fp, sz, lv8);
    tr_n = 0;
    @(negedge clk);
    sp_in = sp; fp_in = fp; size_in = sz; level_in = lv8; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R9", "busy after start", int'(busy), 1);
    if (poke) begin
      @(negedge clk);
      sp_in = ~sp; fp_in = ~fp; size_in = ~sz; level_in = 8'h03; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done !== 1'b1 && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc < 3000, "R9", {tag, " done seen"}, cyc, 0);
    check(sp_out === ex_sp, tag, "sp_out", int'(sp_out), int'(ex_sp));
    check(fp_out === ex_fp, tag, "fp_out", int'(fp_out), int'(ex_fp));
    check(busy === 1'b0, "R9", "busy low with done", int'(busy), 0);
    check(tr_n == ex_n, (lv == 0) ? "R2" : "R3", {tag, " access count"}, tr_n, ex_n);
    if (tr_n >= 1)
      check(tr_we[0] === 1'b1 && tr_addr[0] === ex_addr[0] && tr_data[0] === ex_data[0],
            "R1", "first push addr", int'(tr_addr[0]), int'(ex_addr[0]));
    for (int i = 1; i < ex_n - 1 && i < tr_n; i++)
      if (tr_we[i] !== ex_we[i] || tr_addr[i] !== ex_addr[i] || tr_data[i] !== ex_data[i]) begin
        if (bad == 0)
          check(1'b0, "R3", $sformatf("%s access %0d addr", tag, i),
                int'(tr_addr[i]), int'(ex_addr[i]));
        bad++;
      end
    if (bad == 0 && ex_n > 2) check(1'b1, "R3", "copy pairs", 0, 0);
    if (lv > 0 && tr_n == ex_n)
      check(tr_we[ex_n-1] === 1'b1 && tr_addr[ex_n-1] === ex_addr[ex_n-1] &&
            tr_data[ex_n-1] === ex_data[ex_n-1],
            "R4", "frame value push data", int'(tr_data[ex_n-1]), int'(ex_data[ex_n-1]));
    @(negedge clk);
    check(done === 1'b0, "R9", "done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    tr_n = 0;
    rst_n = 1'b0; start = 1'b0;
    sp_in = '0; fp_in = '0; size_in = '0; level_in = '0;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0, "R9", "reset outputs",
          int'({busy, done, mem_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_req === 1'b0, "R7", "idle no request", int'(mem_req), 0);

    run_case(16'h8000, 16'h8100, 16'h0010, 8'd0,  1'b0, "R2");
    run_case(16'h7F00, 16'h7F40, 16'h0004, 8'd1,  1'b0, "R4");
    run_case(16'h6000, 16'h6020, 16'h0008, 8'd2,  1'b0, "R5");
    run_case(16'hA000, 16'hA080, 16'h0020, 8'd31, 1'b0, "R5");
    run_case(16'h6000, 16'h6020, 16'h0008, 8'hE2, 1'b0, "R6");
    run_case(16'h0002, 16'h0004, 16'h0006, 8'd3,  1'b0, "R10");
    run_case(16'h5000, 16'h5040, 16'h0002, 8'd4,  1'b1, "R8");

    for (int n = 0; n < 20; n++)
      run_case(16'($urandom), 16'($urandom), 16'($urandom),
               8'($urandom), 1'b0, "R5");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule